// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block raises and retires the port-to-port interrupt flags that go with a shared two-port memory. It does not store message words. It watches each port's access controls and address, and decides when a message has been posted to a peer and when that peer has picked the message up. Two words at the top of the address space are reserved as mailboxes:

- The all-ones address belongs to the right port.
- The address one below all-ones belongs to the left port.

A port that writes into its peer's mailbox pulls the peer's active-low interrupt low. The owner then reads its own mailbox, and that read releases the interrupt.

Each port also has an active-low busy input from the arbitration logic. While a port's busy input is low, none of that port's accesses has any effect on the flags. All decisions are taken on the rising clock edge, and both interrupt outputs are registered.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `l_irq_n` and `r_irq_n` are high after that edge.
- R2: A left-port write (`l_en`=1, `l_wr`=1) to address all-ones (2^AW-1), with `l_busy_n`=1, drives `r_irq_n` low after that edge.
- R3: A right-port write (`r_en`=1, `r_wr`=1) to address 2^AW-2, with `r_busy_n`=1, drives `l_irq_n` low after that edge.
- R4: A read (`en`=1, `rd`=1, `wr`=0) by a port of its own mailbox, with that port's busy input high, drives that port's interrupt high after that edge. The left mailbox is at 2^AW-2 and the right mailbox is at 2^AW-1.
- R5: A port reading its peer's mailbox changes neither interrupt.
- R6: A port writing its own mailbox changes neither interrupt.
- R7: While a port's busy input is low, its write to the peer's mailbox does not set the peer's interrupt.
- R8: While a port's busy input is low, its read of its own mailbox does not clear its interrupt.
- R9: If a set and a clear of the same interrupt fall on the same edge, the interrupt ends low.
- R10: With `en`=0, the strobes of that port are ignored. With `wr` and `rd` both high, the access counts as a write. Accesses to any other address leave both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| l_en | input | 1 | Left port access enable |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| l_addr | input | AW | Left port word address |
| l_busy_n | input | 1 | Left port busy, active low |
| r_en | input | 1 | Right port access enable |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_addr | input | AW | Right port word address |
| r_busy_n | input | 1 | Right port busy, active low |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Every interrupt change is due exactly one edge after the access that causes it, because a single register stands between the strobes and each output. The bench therefore drives a cycle's stimulus just after a falling edge and lets one rising edge pass. It compares both outputs at the next falling edge against a bench model advanced by that same edge. Directed sequences cover the same-edge set/clear collision, busy blocking, and writes to a port's own mailbox. Seeded random traffic, biased toward the two mailbox words, then checks every cycle.

// File: rtl/mbx_pkg.sv
// Package: shared types for the mailbox interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017.
package mbx_pkg;

    // Per-port access controls, already decoded from the port pins.
    typedef struct packed {
        logic en;
        logic wr;
        logic rd;
        logic busy_n;
    } mbx_ctl_t;

    // Index of each side in the per-side arrays of the top module.
    localparam int unsigned SIDE_L = 0;
    localparam int unsigned SIDE_R = 1;
    localparam int unsigned NSIDE  = 2;

endpackage

// File: rtl/mbx_port_decode.sv
// Module: mbx_port_decode
// Classifies one port's access on the current cycle. It tells whether the
// access posts a message into the peer's mailbox or retires the port's own
// message.
// Assumes: a write takes precedence when wr and rd are both high, and a low
// busy_n disqualifies every access of the port.
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int unsigned AW         = 14,
    parameter bit          OWN_IS_TOP = 1'b0
) (
    input  mbx_ctl_t        ctl,
    input  logic [AW-1:0]   addr,
    output logic            post_peer,
    output logic            take_own
);
    localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
    localparam logic [AW-1:0] NEXT_ADDR = TOP_ADDR - AW'(1);
    localparam logic [AW-1:0] OWN_ADDR  = OWN_IS_TOP ? TOP_ADDR  : NEXT_ADDR;
    localparam logic [AW-1:0] PEER_ADDR = OWN_IS_TOP ? NEXT_ADDR : TOP_ADDR;

    logic live, is_write, is_read;

    // Qualify the access type: enabled, not blocked by busy, write first.
    always_comb begin
        live     = ctl.en & ctl.busy_n;
        is_write = live & ctl.wr;
        is_read  = live & ctl.rd & ~ctl.wr;
    end

    // Match the qualified access against the two mailbox words.
    always_comb begin
        post_peer = is_write & (addr == PEER_ADDR);
        take_own  = is_read  & (addr == OWN_ADDR);
    end
endmodule

// File: rtl/mbx_irq_flag.sv
// Module: mbx_irq_flag
// Holds one active-low interrupt flag, lowered by a post and raised by a take.
// Assumes: a post and a take on the same edge resolve to the post, so no
// message is lost.
module mbx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic take,
    output logic irq_n
);
    // Update the flag register, with post over take over hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    irq_n <= 1'b1;
        else if (post) irq_n <= 1'b0;
        else if (take) irq_n <= 1'b1;
    end
endmodule

// File: rtl/mbx_irq_ctrl.sv
// Module: mbx_irq_ctrl (top)
// Produces the two port-to-port interrupts of a shared two-port memory. The
// all-ones word is the right mailbox and the word below it is the left one.
// Assumes: both ports are sampled on the same clock, and the data words
// themselves are stored elsewhere.
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_en,
    input  logic          l_wr,
    input  logic          l_rd,
    input  logic [AW-1:0] l_addr,
    input  logic          l_busy_n,
    input  logic          r_en,
    input  logic          r_wr,
    input  logic          r_rd,
    input  logic [AW-1:0] r_addr,
    input  logic          r_busy_n,
    output logic          l_irq_n,
    output logic          r_irq_n
);
    mbx_ctl_t        ctl  [NSIDE];
    logic [AW-1:0]   addr [NSIDE];
    logic [NSIDE-1:0] post, take, irq_n;

    // Gather the port pins into per-side arrays.
    always_comb begin
        ctl[SIDE_L]  = '{en: l_en, wr: l_wr, rd: l_rd, busy_n: l_busy_n};
        ctl[SIDE_R]  = '{en: r_en, wr: r_wr, rd: r_rd, busy_n: r_busy_n};
        addr[SIDE_L] = l_addr;
        addr[SIDE_R] = r_addr;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        mbx_port_decode #(
            .AW         (AW),
            .OWN_IS_TOP (s == SIDE_R)
        ) u_dec (
            .ctl       (ctl[s]),
            .addr      (addr[s]),
            .post_peer (post[s]),
            .take_own  (take[s])
        );

        // A flag is lowered by the other side's post and raised by its own take.
        mbx_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .post  (post[NSIDE-1-s]),
            .take  (take[s]),
            .irq_n (irq_n[s])
        );
    end

    assign l_irq_n = irq_n[SIDE_L];
    assign r_irq_n = irq_n[SIDE_R];
endmodule

// File: rtl/mbx_irq_checker.sv
// Module: mbx_irq_checker
// Port-level properties of mbx_irq_ctrl, attached to it by bind.
// Assumes: the same AW as the bound instance.
module mbx_irq_checker #(
    parameter int unsigned AW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l_en,
    input logic          l_wr,
    input logic          l_rd,
    input logic [AW-1:0] l_addr,
    input logic          l_busy_n,
    input logic          r_en,
    input logic          r_wr,
    input logic          r_rd,
    input logic [AW-1:0] r_addr,
    input logic          r_busy_n,
    input logic          l_irq_n,
    input logic          r_irq_n
);
    localparam logic [AW-1:0] R_BOX = {AW{1'b1}};
    localparam logic [AW-1:0] L_BOX = R_BOX - AW'(1);

    logic set_r, set_l, clr_r, clr_l;

    // Port-level view of the four events.
    always_comb begin
        set_r = l_en & l_wr & l_busy_n & (l_addr == R_BOX);
        set_l = r_en & r_wr & r_busy_n & (r_addr == L_BOX);
        clr_r = r_en & r_rd & ~r_wr & r_busy_n & (r_addr == R_BOX);
        clr_l = l_en & l_rd & ~l_wr & l_busy_n & (l_addr == L_BOX);
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (l_irq_n && r_irq_n));

    assert_left_post_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_r |=> !r_irq_n);

    assert_right_post_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_l |=> !l_irq_n);

    assert_take_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_r && !set_r) |=> r_irq_n);

    assert_take_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_l && !set_l) |=> l_irq_n);

    // R7: the right flag can only fall through an unblocked left post.
    assert_busy_blocks_post_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_irq_n && !l_busy_n) |=> r_irq_n);

    // R8: the left flag can only rise through an unblocked left take.
    assert_busy_blocks_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_irq_n && !l_busy_n) |=> !l_irq_n);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_r && !set_l && !clr_r && !clr_l) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

bind mbx_irq_ctrl mbx_irq_checker #(.AW(AW)) u_mbx_irq_checker (.*);

// File: tb/test_mbx_irq_ctrl.sv
module test_mbx_irq_ctrl;
    localparam int unsigned AW = 14;
    localparam logic [AW-1:0] R_BOX = {AW{1'b1}};
    localparam logic [AW-1:0] L_BOX = R_BOX - AW'(1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en = 0, l_wr = 0, l_rd = 0, l_busy_n = 1;
    logic r_en = 0, r_wr = 0, r_rd = 0, r_busy_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic exp_l = 1'b1, exp_r = 1'b1;

    always #10 clk = ~clk;

    mbx_irq_ctrl #(.AW(AW)) i_mbx_irq_ctrl (.*);

    // Next expected flag: a post wins over a take, otherwise hold.
    function automatic logic next_flag(logic cur, logic post, logic take);
        if (post) return 1'b0;
        if (take) return 1'b1;
        return cur;
    endfunction

    function automatic logic is_post(logic en, logic wr, logic bn, logic [AW-1:0] a,
                                     logic [AW-1:0] box);
        return en & wr & bn & (a == box);
    endfunction

    function automatic logic is_take(logic en, logic wr, logic rd, logic bn,
                                     logic [AW-1:0] a, logic [AW-1:0] box);
        return en & rd & ~wr & bn & (a == box);
    endfunction

    task automatic check(string tag);
        n_chk++;
        if (l_irq_n !== exp_l || r_irq_n !== exp_r) begin
            n_bad++;
            $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b",
                     tag, l_irq_n, r_irq_n, exp_l, exp_r);
        end
    endtask

    // One cycle: drive after a falling edge, model the rising edge, compare.
    task automatic step(input logic le, lw, lr, lb, input logic [AW-1:0] la,
                        input logic re, rw, rr, rb, input logic [AW-1:0] ra,
                        input string tag);
        l_en = le; l_wr = lw; l_rd = lr; l_busy_n = lb; l_addr = la;
        r_en = re; r_wr = rw; r_rd = rr; r_busy_n = rb; r_addr = ra;
        @(posedge clk);
        if (!rst_n) begin
            exp_l = 1'b1; exp_r = 1'b1;
        end else begin
            exp_r = next_flag(exp_r, is_post(le, lw, lb, la, R_BOX),
                              is_take(re, rw, rr, rb, ra, R_BOX));
            exp_l = next_flag(exp_l, is_post(re, rw, rb, ra, L_BOX),
                              is_take(le, lw, lr, lb, la, L_BOX));
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 1, '0, 0, 0, 0, 1, '0, tag);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        case ($urandom_range(3))
            0:       return R_BOX;
            1:       return L_BOX;
            2:       return R_BOX - AW'(2);
            default: return AW'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        idle("R1 reset");
        idle("R1 reset hold");
        rst_n = 1'b1;
        idle("R10 idle");

        step(1, 1, 0, 1, R_BOX, 0, 0, 0, 1, '0, "R2 left posts");
        step(1, 1, 0, 1, L_BOX, 0, 0, 0, 1, '0, "R6 left writes own box");
        step(0, 0, 0, 1, '0, 1, 0, 1, 1, L_BOX, "R5 right reads peer box");
        step(0, 0, 0, 1, '0, 1, 0, 1, 0, R_BOX, "R8 right take blocked");
        step(0, 0, 0, 1, '0, 1, 0, 1, 1, R_BOX, "R4 right takes");
        step(0, 0, 0, 1, '0, 1, 1, 0, 0, L_BOX, "R7 right post blocked");
        step(0, 0, 0, 1, '0, 1, 1, 0, 1, L_BOX, "R3 right posts");
        step(0, 1, 1, 1, L_BOX, 0, 0, 0, 1, '0, "R10 left disabled read");
        step(1, 1, 1, 1, L_BOX, 0, 0, 0, 1, '0, "R10 wr+rd is write");
        step(1, 0, 1, 1, R_BOX, 1, 1, 0, 1, R_BOX, "R6 R5 mixed");
        step(1, 0, 1, 1, L_BOX, 1, 1, 0, 1, L_BOX, "R9 collide left");
        step(1, 0, 1, 1, L_BOX, 0, 0, 0, 1, '0, "R4 left takes");
        step(1, 1, 0, 1, R_BOX, 1, 0, 1, 1, R_BOX, "R9 collide right");
        step(1, 1, 0, 1, R_BOX - AW'(2), 1, 1, 0, 1, '0, "R10 other address");

        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(3) != 0, $urandom_range(1), $urandom_range(1),
                 $urandom_range(4) != 0, pick_addr(),
                 $urandom_range(3) != 0, $urandom_range(1), $urandom_range(1),
                 $urandom_range(4) != 0, pick_addr(), "R2 R3 R4 R9 random");
        end

        rst_n = 1'b0;
        step(1, 1, 0, 1, R_BOX, 1, 1, 0, 1, L_BOX, "R1 reset over post");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule